// File: doc/BRIEF.md
# Thermometer-to-Injection Control Decoder

This block sits behind the phase comparators of an interleaved measurement delay line. Each tap of that line is sampled against a reference clock, and the odd taps use the inverted reference, so their raw bits arrive with the opposite sense. The block brings every comparison bit into the local clock domain and puts the odd taps back into true sense. It then tolerates a single-bit bubble and finds the boundary index `k` of the leading run of ones. From `k` it builds the two control vectors for the compensation delay chain.

The injection vector is one-hot at `k`. The pass vector is a thermometer that is high from tap 0 up to and including `k`. Together they give every compensation unit one of three legal codes: blocked (inject 0, pass 0), pass-through (inject 0, pass 1) or injection point (inject 1, pass 1). The code inject 1 with pass 0 never appears.

The vectors are registered, so the decode logic is not in any clock path. They change only on a measurement strobe. The output side is a valid-only stream with no back-pressure: `ctrl_valid` pulses for one cycle after each strobe, and the receiver must take the vectors on that cycle. The vectors then hold until the next strobe.

Top module: `inj_ctrl_decoder`

## Requirements
- R1: Each tap bit passes through a two-flop synchronizer. A strobe sampled at a clock edge decodes the tap values that were present two edges earlier. A tap change made less than two edges before the strobe edge is not seen.
- R2: Odd-indexed taps are inverted before decoding. Even-indexed taps are used as they are. Bit i of `tap_raw` is tap i.
- R3: A single zero at an index from 1 to N-2 whose two neighbours (after polarity correction) are both one is treated as one. Two or more adjacent zeros are not filled.
- R4: `pass_vec` bits 0 through k are one and bits k+1 through N-1 are zero. Here k is the highest index such that that bit and every lower bit are one after correction and bubble filling.
- R5: `inj_vec` has exactly one bit set, at index k.
- R6: No bit position ever has `inj_vec` set while `pass_vec` is clear.
- R7: If corrected tap 0 is zero, including the case where no tap is one, then k is 0: `inj_vec` = 1 and `pass_vec` = 1.
- R8: `inj_vec` and `pass_vec` load only at a clock edge where `meas_stb` is high, and hold at all other edges. `ctrl_valid` is high for exactly the cycle after each strobe edge.
- R9: While reset is asserted, `ctrl_valid` is 0, `inj_vec` = 1, `pass_vec` = 1, and both synchronizer stages are cleared.
- R10: When all corrected taps are one, k = N-1: `pass_vec` is all ones and only the top bit of `inj_vec` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_raw | input | N_TAPS | Raw comparator bits from the measurement line, asynchronous to `clk` |
| meas_stb | input | 1 | Measurement strobe: latch a new decode at this edge |
| ctrl_valid | output | 1 | One-cycle pulse that marks newly loaded vectors |
| inj_vec | output | N_TAPS | One-hot injection control vector |
| pass_vec | output | N_TAPS | Thermometer pass control vector |

## Verification
The bench hits single bubbles next to pairs of zeros. A design that fills too much would move k past a real edge, and one that fills nothing would stop k at the bubble. It drives patterns where tap 0 is zero and where every tap is one. Getting these ends wrong shows up as an all-zero injection vector or a boundary that runs past the top. It strobes one edge too early after a tap change, which shows whether the synchronizer depth is wrong. It also holds the strobe low while the taps change, which catches vectors that follow the live taps instead of the strobe. Raw all-zero and alternating inputs show whether the odd taps get their polarity correction.

// File: rtl/icd_pkg.sv
package icd_pkg;
  // Synchronizer depth used for every comparator bit.
  localparam int unsigned ICD_SYNC_DEPTH = 2;
  // Default number of taps in the measurement line.
  localparam int unsigned ICD_TAPS_DEF = 16;
endpackage

// File: rtl/icd_tap_sync.sv
module icd_tap_sync #(
  parameter int unsigned WIDTH  = icd_pkg::ICD_TAPS_DEF,
  parameter int unsigned STAGES = icd_pkg::ICD_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/icd_condition.sv
module icd_condition #(
  parameter int unsigned WIDTH = icd_pkg::ICD_TAPS_DEF
) (
  input  logic [WIDTH-1:0] sampled,
  output logic [WIDTH-1:0] filled
);
  logic [WIDTH-1:0] true_sense;

  // Odd taps were compared against the inverted reference.
  for (genvar i = 0; i < WIDTH; i++) begin : g_pol
    if ((i % 2) == 1) begin : g_odd
      assign true_sense[i] = ~sampled[i];
    end else begin : g_even
      assign true_sense[i] = sampled[i];
    end
  end

  // A lone zero between two ones is a bubble; the end taps are never filled.
  for (genvar i = 0; i < WIDTH; i++) begin : g_fill
    if (i == 0 || i == WIDTH - 1) begin : g_edge
      assign filled[i] = true_sense[i];
    end else begin : g_mid
      assign filled[i] = true_sense[i] | (true_sense[i-1] & true_sense[i+1]);
    end
  end
endmodule

// File: rtl/icd_boundary.sv
module icd_boundary #(
  parameter int unsigned WIDTH = icd_pkg::ICD_TAPS_DEF
) (
  input  logic [WIDTH-1:0] filled,
  output logic [WIDTH-1:0] pass_next,
  output logic [WIDTH-1:0] inj_next
);
  logic [WIDTH-1:0] run;

  // Prefix AND: run[i] is one only while every tap up to i is one.
  assign run[0] = filled[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_run
    assign run[i] = run[i-1] & filled[i];
  end

  // Unit 0 always passes, so an empty run still yields k = 0.
  assign pass_next = run | {{(WIDTH-1){1'b0}}, 1'b1};

  // Injection point is the last passing unit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_inj
    if (i == WIDTH - 1) begin : g_top
      assign inj_next[i] = pass_next[i];
    end else begin : g_low
      assign inj_next[i] = pass_next[i] & ~pass_next[i+1];
    end
  end
endmodule

// File: rtl/inj_ctrl_decoder.sv
module inj_ctrl_decoder #(
  parameter int unsigned N_TAPS = icd_pkg::ICD_TAPS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tap_raw,
  input  logic              meas_stb,
  output logic              ctrl_valid,
  output logic [N_TAPS-1:0] inj_vec,
  output logic [N_TAPS-1:0] pass_vec
);
  localparam logic [N_TAPS-1:0] UNIT0 = {{(N_TAPS-1){1'b0}}, 1'b1};

  logic [N_TAPS-1:0] tap_sync;
  logic [N_TAPS-1:0] tap_filled;
  logic [N_TAPS-1:0] pass_d;
  logic [N_TAPS-1:0] inj_d;

  icd_tap_sync #(.WIDTH(N_TAPS), .STAGES(icd_pkg::ICD_SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (tap_raw),
    .sync_out (tap_sync)
  );

  icd_condition #(.WIDTH(N_TAPS)) u_cond (
    .sampled (tap_sync),
    .filled  (tap_filled)
  );

  icd_boundary #(.WIDTH(N_TAPS)) u_bound (
    .filled    (tap_filled),
    .pass_next (pass_d),
    .inj_next  (inj_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_valid <= 1'b0;
      inj_vec    <= UNIT0;
      pass_vec   <= UNIT0;
    end else begin
      ctrl_valid <= meas_stb;
      if (meas_stb) begin
        inj_vec  <= inj_d;
        pass_vec <= pass_d;
      end
    end
  end

  // R5
  inj_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(inj_vec));

  // R6
  no_inject_without_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vec & ~pass_vec) == '0);

  // R4
  pass_thermometer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_vec[0] && ((pass_vec & (pass_vec + UNIT0)) == '0));

  // R8
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb |=> ctrl_valid);

  // R8
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_stb |=> (!ctrl_valid && $stable(inj_vec) && $stable(pass_vec)));
endmodule

// File: tb/inj_ctrl_decoder_tb.sv
module inj_ctrl_decoder_tb;
  localparam int N = 16;
  localparam logic [N-1:0] ODD = 16'hAAAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] tap_raw = '0;
  logic meas_stb = 1'b0;
  logic ctrl_valid;
  logic [N-1:0] inj_vec, pass_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  inj_ctrl_decoder #(.N_TAPS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .tap_raw(tap_raw), .meas_stb(meas_stb),
    .ctrl_valid(ctrl_valid), .inj_vec(inj_vec), .pass_vec(pass_vec)
  );

  // Behavioural boundary search from the requirements.
  function automatic int find_k(logic [N-1:0] raw);
    int c[N];
    int f[N];
    int k;
    for (int i = 0; i < N; i++) c[i] = ((i % 2) == 1) ? (raw[i] ? 0 : 1) : (raw[i] ? 1 : 0);
    for (int i = 0; i < N; i++) begin
      f[i] = c[i];
      if (i > 0 && i < N - 1 && c[i] == 0 && c[i-1] == 1 && c[i+1] == 1) f[i] = 1;
    end
    k = 0;
    for (int i = 0; i < N; i++) begin
      if (f[i] == 0) break;
      k = i;
    end
    return k;
  endfunction

  function automatic logic [N-1:0] therm(int k);
    logic [N-1:0] v = '0;
    for (int i = 0; i <= k; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Cycle model: a two-entry delay for the synchronizer, registered outputs.
  logic [N-1:0] m_q1, m_q2, exp_inj, exp_pass;
  logic exp_valid;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_q1 <= '0; m_q2 <= '0; exp_valid <= 1'b0;
      exp_inj <= 16'h0001; exp_pass <= 16'h0001;
    end else begin
      if (meas_stb) begin
        exp_pass <= therm(find_k(m_q2));
        exp_inj  <= 16'h0001 << find_k(m_q2);
      end
      exp_valid <= meas_stb;
      m_q2 <= m_q1;
      m_q1 <= tap_raw;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (ctrl_valid !== exp_valid || pass_vec !== exp_pass || inj_vec !== exp_inj) begin
        errors++;
        $display("FAIL R8/R4/R5 cycle compare: valid=%b pass=%h inj=%h expected valid=%b pass=%h inj=%h",
                 ctrl_valid, pass_vec, inj_vec, exp_valid, exp_pass, exp_inj);
      end
    end
  end

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Apply a corrected pattern, let it settle, strobe, sample after the load.
  task automatic measure(logic [N-1:0] corr);
    @(negedge clk) tap_raw = corr ^ ODD;
    repeat (2) @(negedge clk);
    meas_stb = 1'b1;
    @(negedge clk) meas_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", {15'd0, ctrl_valid}, 16'h0000);
    chk("R9 inj", inj_vec, 16'h0001);
    chk("R9 pass", pass_vec, 16'h0001);
    @(negedge clk) rst_n = 1'b1;

    measure(16'h00FF);              // R4 R5 plain edge at k=7
    chk("R4 pass", pass_vec, 16'h00FF);
    chk("R5 inj", inj_vec, 16'h0080);
    chk("R8 valid pulse", {15'd0, ctrl_valid}, 16'h0001);
    @(negedge clk);
    chk("R8 valid drops", {15'd0, ctrl_valid}, 16'h0000);

    measure(16'h00FB);              // R3 lone bubble at 2
    chk("R3 bubble filled", pass_vec, 16'h00FF);
    measure(16'h00F3);              // R3 two zeros not filled
    chk("R3 no fill", pass_vec, 16'h0003);
    chk("R6 inj within pass", inj_vec & ~pass_vec, 16'h0000);
    measure(16'h7FFF);              // R3 top tap never filled
    chk("R3 top edge", inj_vec, 16'h4000);
    measure(16'h0000);              // R7 no ones
    chk("R7 inj", inj_vec, 16'h0001);
    chk("R7 pass", pass_vec, 16'h0001);
    measure(16'hFFF0);              // R7 tap 0 low
    chk("R7 tap0 low", pass_vec, 16'h0001);
    measure(16'hFFFF);              // R10 all ones
    chk("R10 pass", pass_vec, 16'hFFFF);
    chk("R10 inj", inj_vec, 16'h8000);

    // R2: raw zeros mean even taps low, odd taps high -> k=0
    @(negedge clk) tap_raw = 16'h0000;
    repeat (2) @(negedge clk); meas_stb = 1'b1;
    @(negedge clk) meas_stb = 1'b0;
    chk("R2 raw zeros", pass_vec, 16'h0001);
    @(negedge clk) tap_raw = 16'h5555;
    repeat (2) @(negedge clk); meas_stb = 1'b1;
    @(negedge clk) meas_stb = 1'b0;
    chk("R2 raw 5555", pass_vec, 16'hFFFF);

    // R1: strobe one edge after the change sees the previous value
    measure(16'h000F);
    @(negedge clk) tap_raw = 16'h03FF ^ ODD;
    @(negedge clk) meas_stb = 1'b1;
    @(negedge clk) meas_stb = 1'b0;
    chk("R1 too early", pass_vec, 16'h000F);
    meas_stb = 1'b1;
    @(negedge clk) meas_stb = 1'b0;
    chk("R1 settled", pass_vec, 16'h03FF);

    // R8: taps move without a strobe, outputs hold
    @(negedge clk) tap_raw = 16'h001F ^ ODD;
    repeat (4) @(negedge clk);
    chk("R8 hold pass", pass_vec, 16'h03FF);
    chk("R8 hold valid", {15'd0, ctrl_valid}, 16'h0000);

    // Free-running mix against the cycle model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      tap_raw = ($urandom % 3 == 0) ? N'($urandom) : (therm($urandom % N) ^ ODD);
      meas_stb = ($urandom % 2) == 1;
    end
    @(negedge clk) meas_stb = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule